// File: doc/BRIEF.md
# SDRAM refresh keeper

This block keeps the contents of a synchronous DRAM alive. While the memory is awake, a timer divides the refresh period by the number of refreshes needed in that period. Each expiry adds one refresh to a count of owed refreshes. The block asks the command sequencer for auto-refresh cycles through a request/grant handshake and subtracts one refresh for every cycle the sequencer accepts. Refreshes may be postponed up to a limit. When the count reaches that limit, the block raises a hold that stops new host accesses. If the timer expires while the count is already at the limit, the refresh period counts as lapsed. The block then requires two wake-up refreshes before host traffic may resume. The same two refreshes are required after reset, because the memory's state is unknown at that point.

The block also handles self-refresh for a sleeping host. A sleep request is honoured only when all banks are precharged and no wake-up refreshes are outstanding. CKE then goes low and the owed count is cleared, because the device now refreshes itself. When the sleep request drops, CKE goes high again. The block keeps host traffic and refresh requests off the bus for the row cycle time, then pulses a wake acknowledge.

The refresh handshake follows valid/ready rules. Once `ref_req` is raised, it stays high until enough refreshes have been accepted. A refresh counts only in a cycle where `ref_req`, `ref_gnt` and `banks_idle` are all high at the rising edge. The sequencer may hold off the block indefinitely by keeping `ref_gnt` low. The only effect of holding off is that `host_hold` is raised once the limit is reached.

Top module: `sdram_refresh_keeper`

## Requirements
- R1: While reset is low and just after it, `cke` = 1, `ref_req` = 1, `host_hold` = 1 and `wake_ack` = 0. Two wake-up refreshes are owed.
- R2: A refresh is accepted only at a rising edge where `ref_req`, `ref_gnt` and `banks_idle` are all 1. A grant while `banks_idle` = 0 has no effect and `ref_req` stays high.
- R3: While awake, one refresh is added to the owed count every INTERVAL = floor(PERIOD_US * CLK_KHZ / (1000 * REFS_PER_PERIOD)) clocks. With a grant held, `ref_req` rises once every INTERVAL clocks.
- R4: `ref_req` is high while any refresh is owed. Each acceptance removes one refresh. After k timer expiries with no grant (k ≤ MAX_OWED), exactly k acceptances bring `ref_req` low.
- R5: `host_hold` rises when the owed count reaches MAX_OWED and is 0 below it, when no wake-up refresh is due.
- R6: An expiry while the owed count is at MAX_OWED leaves the count at MAX_OWED and adds WAKE_REFS (2) wake-up refreshes. `host_hold` stays high until all are accepted, so MAX_OWED+2 acceptances are needed.
- R7: While awake, `sleep_req` = 1 with `banks_idle` = 1 and no wake-up refresh due drives `cke` low at the next edge and clears the owed count. Without `banks_idle`, or with wake-up refreshes due, `cke` stays 1.
- R8: While `cke` is low, `ref_req` = 0 and `host_hold` = 1, and the refresh timer does not advance.
- R9: Once `sleep_req` drops during sleep, `cke` is 1 from the next edge. `host_hold` stays high for TRFC_CLKS cycles, then `wake_ack` pulses for one cycle. The timer restarts from zero, so the first new `ref_req` appears INTERVAL clocks after `wake_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Host asks for self-refresh (level) |
| banks_idle | input | 1 | All banks precharged, from the sequencer |
| ref_gnt | input | 1 | Sequencer accepts the refresh request |
| ref_req | output | 1 | Auto-refresh requested |
| host_hold | output | 1 | Block new host accesses |
| cke | output | 1 | Clock enable for the SDRAM |
| wake_ack | output | 1 | One-cycle pulse: self-refresh exit complete |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- no refresh request and an active hold while CKE is low;
- CKE falls only after a sleep request made while the banks are idle, and rises only after the request is withdrawn;
- the wake acknowledge is a clean single pulse;
- a request never drops, or goes away, without an accepted grant or a sleep entry.

Only the bench scenarios can show the counting behaviour:
- the exact refresh interval;
- how many acceptances clear k postponed refreshes, swept from one up to a lapsed period;
- where the hold threshold lies;
- the length of the post-exit NOP window;
- the timer restarting from zero after wake.

// File: rtl/sdr_ref_pkg.sv
package sdr_ref_pkg;

  typedef enum logic [1:0] {
    PH_AWAKE  = 2'd0,
    PH_ASLEEP = 2'd1,
    PH_WAKING = 2'd2
  } phase_t;

  // Clocks between refresh ticks, rounded down.
  function automatic int unsigned refresh_gap(input longint unsigned khz,
                                              input longint unsigned us,
                                              input longint unsigned refs);
    longint unsigned q;
    q = (us * khz) / (64'd1000 * refs);
    return 32'(q);
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned IVL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = (IVL < 2) ? 1 : $clog2(IVL);

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == TW'(IVL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/ref_debt_tracker.sv
module ref_debt_tracker #(
  parameter int unsigned MAX_OWED  = 8,
  parameter int unsigned WAKE_REFS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic accept,
  input  logic clear,
  output logic owed_any,
  output logic owed_full,
  output logic wake_due
);
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam int LW = $clog2(WAKE_REFS + 1);

  logic [OW-1:0] owed;
  logic [LW-1:0] wake_left;
  logic take_wake, take_owed, overflow;

  // Wake-up refreshes are paid off before postponed ones.
  assign take_wake = accept && (wake_left != '0);
  assign take_owed = accept && (wake_left == '0) && (owed != '0);
  assign overflow  = tick && (owed == OW'(MAX_OWED)) && !take_owed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed      <= '0;
      wake_left <= LW'(WAKE_REFS);
    end else if (clear) begin
      owed      <= '0;
      wake_left <= '0;
    end else begin
      if (overflow)       wake_left <= LW'(WAKE_REFS);
      else if (take_wake) wake_left <= wake_left - LW'(1);

      if (tick && !overflow && !take_owed) owed <= owed + OW'(1);
      else if (!tick && take_owed)         owed <= owed - OW'(1);
    end
  end

  assign owed_any  = (owed != '0);
  assign owed_full = (owed == OW'(MAX_OWED));
  assign wake_due  = (wake_left != '0);
endmodule

// File: rtl/selfref_fsm.sv
module selfref_fsm
  import sdr_ref_pkg::*;
#(
  parameter int unsigned TRFC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic banks_idle,
  input  logic wake_block,
  output logic awake,
  output logic enter,
  output logic cke,
  output logic wake_ack
);
  localparam int WW = (TRFC < 2) ? 1 : $clog2(TRFC);

  phase_t        ph;
  logic [WW-1:0] wcnt;

  assign awake = (ph == PH_AWAKE);
  assign enter = awake && sleep_req && banks_idle && !wake_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_AWAKE;
      cke      <= 1'b1;
      wake_ack <= 1'b0;
      wcnt     <= '0;
    end else begin
      wake_ack <= 1'b0;
      case (ph)
        PH_AWAKE: if (enter) begin
          ph  <= PH_ASLEEP;
          cke <= 1'b0;
        end
        PH_ASLEEP: if (!sleep_req) begin
          ph   <= PH_WAKING;
          cke  <= 1'b1;
          wcnt <= '0;
        end
        PH_WAKING: if (wcnt == WW'(TRFC - 1)) begin
          ph       <= PH_AWAKE;
          wake_ack <= 1'b1;
        end else begin
          wcnt <= wcnt + WW'(1);
        end
        default: ph <= PH_AWAKE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_refresh_keeper.sv
module sdram_refresh_keeper
  import sdr_ref_pkg::*;
#(
  parameter int unsigned CLK_KHZ         = 100000,
  parameter int unsigned PERIOD_US       = 64000,
  parameter int unsigned REFS_PER_PERIOD = 4096,
  parameter int unsigned MAX_OWED        = 8,
  parameter int unsigned TRFC_CLKS       = 8,
  parameter int unsigned WAKE_REFS       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic banks_idle,
  input  logic ref_gnt,
  output logic ref_req,
  output logic host_hold,
  output logic cke,
  output logic wake_ack
);
  localparam int unsigned IVL = refresh_gap(CLK_KHZ, PERIOD_US, REFS_PER_PERIOD);

  logic awake, enter, tick, accept;
  logic owed_any, owed_full, wake_due;

  assign accept    = ref_req && ref_gnt && banks_idle;
  assign ref_req   = awake && (owed_any || wake_due);
  assign host_hold = !awake || owed_full || wake_due;

  ref_interval_timer #(.IVL(IVL)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(awake), .tick(tick)
  );

  ref_debt_tracker #(.MAX_OWED(MAX_OWED), .WAKE_REFS(WAKE_REFS)) debt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .accept(accept), .clear(enter),
    .owed_any(owed_any), .owed_full(owed_full), .wake_due(wake_due)
  );

  selfref_fsm #(.TRFC(TRFC_CLKS)) fsm_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .banks_idle(banks_idle),
    .wake_block(wake_due), .awake(awake), .enter(enter), .cke(cke),
    .wake_ack(wake_ack)
  );
endmodule

// File: rtl/sdram_refresh_keeper_chk.sv
module sdram_refresh_keeper_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic banks_idle,
  input logic ref_gnt,
  input logic ref_req,
  input logic host_hold,
  input logic cke,
  input logic wake_ack
);
  a_r8_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!ref_req && host_hold));

  a_r7_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(sleep_req && banks_idle));

  a_r9_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(!sleep_req));

  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |=> !wake_ack);

  a_r9_ack_clean: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |-> (cke && !host_hold && !ref_req));

  a_r4_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_req) |-> ($past(ref_gnt && banks_idle) || !cke));

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !(ref_gnt && banks_idle)) |=> (ref_req || !cke));
endmodule

bind sdram_refresh_keeper sdram_refresh_keeper_chk chk_i (.*);

// File: tb/sdram_refresh_keeper_tb_top.sv
`timescale 1ns/1ps
module sdram_refresh_keeper_tb_top;
  localparam int CLK_KHZ = 1000;
  localparam int PERIOD_US = 640;
  localparam int REFS = 16;
  localparam int MAXO = 4;
  localparam int TRFC = 5;
  localparam int IVL = (PERIOD_US * CLK_KHZ) / (1000 * REFS);  // 40

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, banks_idle = 1'b0, ref_gnt = 1'b0;
  logic ref_req, host_hold, cke, wake_ack;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  sdram_refresh_keeper #(
    .CLK_KHZ(CLK_KHZ), .PERIOD_US(PERIOD_US), .REFS_PER_PERIOD(REFS),
    .MAX_OWED(MAXO), .TRFC_CLKS(TRFC), .WAKE_REFS(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .banks_idle(banks_idle),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .host_hold(host_hold), .cke(cke),
    .wake_ack(wake_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Grant until a request is seen and taken; return one cycle after a tick.
  task automatic align();
    ref_gnt = 1'b1;
    while (!ref_req) @(negedge clk);
    @(negedge clk);
    ref_gnt = 1'b0;
  endtask

  // Hold the grant and count acceptances until the request drops.
  task automatic drain(output int cnt);
    cnt = 0;
    ref_gnt = 1'b1;
    while (ref_req && cnt < 50) begin
      @(negedge clk);
      cnt++;
    end
    ref_gnt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int cnt, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(cke == 1'b1, "R1 cke", int'(cke), 1);
    chk(ref_req == 1'b1, "R1 ref_req", int'(ref_req), 1);
    chk(host_hold == 1'b1, "R1 host_hold", int'(host_hold), 1);
    chk(wake_ack == 1'b0, "R1 wake_ack", int'(wake_ack), 0);

    // R7: no sleep entry while wake-up refreshes are due
    sleep_req = 1'b1; banks_idle = 1'b1;
    repeat (3) @(negedge clk);
    chk(cke == 1'b1, "R7 blocked by wake-up", int'(cke), 1);
    sleep_req = 1'b0;

    // R2: grant without idle banks is ignored
    banks_idle = 1'b0; ref_gnt = 1'b1;
    repeat (5) @(negedge clk);
    chk(ref_req == 1'b1, "R2 grant not idle", int'(ref_req), 1);
    ref_gnt = 1'b0; banks_idle = 1'b1;
    drain(cnt);
    chk(cnt == 2, "R1 wake-up refresh count", cnt, 2);
    chk(host_hold == 1'b0, "R6 hold released", int'(host_hold), 0);

    // R3: request period with grant held
    ref_gnt = 1'b1;
    while (!ref_req) @(negedge clk);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!ref_req && cnt < 200);
    chk(cnt == IVL, "R3 interval", cnt, IVL);
    @(negedge clk);
    ref_gnt = 1'b0;

    // R4 R5 R6: sweep number of postponed ticks
    for (int k = 1; k <= MAXO + 1; k++) begin
      int expn;
      align();
      repeat (IVL * k - 1) @(negedge clk);
      chk(host_hold == (k >= MAXO), "R5 hold at k ticks", int'(host_hold), int'(k >= MAXO));
      expn = (k <= MAXO) ? k : MAXO + 2;
      drain(cnt);
      chk(cnt == expn, (k <= MAXO) ? "R4 drain count" : "R6 lapse drain count", cnt, expn);
      chk(host_hold == 1'b0, "R6 hold after drain", int'(host_hold), 0);
    end

    // R7 R8 R9: self-refresh cycle with two owed refreshes
    align();
    repeat (IVL * 2 - 1) @(negedge clk);
    chk(ref_req == 1'b1, "R4 owed before sleep", int'(ref_req), 1);
    banks_idle = 1'b0; sleep_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(cke == 1'b1, "R7 blocked by busy banks", int'(cke), 1);
    banks_idle = 1'b1;
    @(negedge clk);
    chk(cke == 1'b0, "R7 entry", int'(cke), 0);
    chk(ref_req == 1'b0 && host_hold == 1'b1, "R8 quiet on entry",
        int'({ref_req, host_hold}), 1);
    bad = 0;
    repeat (IVL * 5) begin
      @(negedge clk);
      if (ref_req || cke || !host_hold) bad++;
    end
    chk(bad == 0, "R8 sleep quiet cycles", bad, 0);
    sleep_req = 1'b0;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1)
        chk(cke == 1'b1 && host_hold == 1'b1, "R9 exit cke/hold",
            int'({cke, host_hold}), 3);
    end while (!wake_ack && cnt < 50);
    chk(cnt == TRFC + 1, "R9 nop window", cnt, TRFC + 1);
    chk(ref_req == 1'b0 && host_hold == 1'b0, "R7 owed cleared",
        int'({ref_req, host_hold}), 0);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) chk(wake_ack == 1'b0, "R9 ack pulse", int'(wake_ack), 0);
    end while (!ref_req && cnt < 200);
    chk(cnt == IVL, "R9 timer restart", cnt, IVL);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule